// File: doc/BRIEF.md
# Peripheral Interrupt Source Controller

This block collects eight asynchronous event lines from a peripheral and turns them into a single interrupt request. Each line is first brought into the local clock domain. A per-line rule then decides whether the line has raised an event: edge sensing (rising, falling or both) or level sensing (active high or active low). Events are held in a latched status register until software clears them. An enable mask selects which latched events may drive the interrupt output.

All control goes through a byte-wide register port that is written in one cycle and read combinationally. The serial transport that normally carries these accesses sits outside the block. Several registers are split into write-one-to-set and write-one-to-clear offsets, so software can change single bits without a read-modify-write. The three sensing-configuration bytes sit at consecutive offsets so that they can be moved as one burst.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After reset every readable offset returns 0x00, and `irq_o` is 0.
- R2: Offset 0x10 returns the synchronised line states, with bit n for line n. A change on `line_in` appears there on the second rising clock edge after it is driven.
- R3: In level mode (bit n of offset 0x11 is 0), line n latches while it is high if bit n of 0x12 is set, and while it is low if bit n of 0x13 is set. With neither bit set the line never latches, and an inactive level does not latch.
- R4: In edge mode (bit n of offset 0x11 is 1), bit n of 0x12 enables latching on a rising edge and bit n of 0x13 enables latching on a falling edge. Both may be set together. A line that stays at a steady level does not latch again after it is cleared.
- R5: Offset 0x18 returns the latched status. Writing 1s to offset 0x14 clears the matching latched bits and leaves bits written 0 untouched. A clear wins over a detection in the same cycle. Offset 0x14 reads 0x00.
- R6: In level mode, a line whose active level persists latches again on the clock edge after the one that cleared it.
- R7: Writing 1s to offset 0x15 sets enable bits and writing 1s to offset 0x16 clears them. Bits written 0 leave the enable unchanged. The enable mask reads back at both 0x15 and 0x16.
- R8: `irq_o` is a register holding the OR over all lines of (latched AND enable). It follows a change of latched status or enable one clock edge later.
- R9: Reads of any offset other than 0x10 to 0x16 and 0x18 return 0x00. Writes to such offsets change no state.
- R10: Offsets 0x11 (type), 0x12 (high polarity) and 0x13 (low polarity) read back the values last written, in that consecutive order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 8 | Asynchronous peripheral event lines |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a write strobe lasts a single cycle, with address and data stable around that clock edge, and that reset is applied before any access. The bench drives every port on the falling clock edge and raises `reg_wr` for exactly one cycle per write. It changes `line_in` only after enough cycles for the synchroniser and the edge history to settle, so every detection it expects comes from one known transition. Sensing configuration changes are made only while the lines are steady and the current rule cannot fire, so reconfiguring never creates an event the bench does not expect.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int OFS_W = 8;
    localparam logic [OFS_W-1:0] OFS_LIVE   = 8'h10;
    localparam logic [OFS_W-1:0] OFS_KIND   = 8'h11;
    localparam logic [OFS_W-1:0] OFS_POLHI  = 8'h12;
    localparam logic [OFS_W-1:0] OFS_POLLO  = 8'h13;
    localparam logic [OFS_W-1:0] OFS_ACKCLR = 8'h14;
    localparam logic [OFS_W-1:0] OFS_ENSET  = 8'h15;
    localparam logic [OFS_W-1:0] OFS_ENCLR  = 8'h16;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h18;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live,
    input  logic [W-1:0] kind,
    input  logic [W-1:0] pol_hi,
    input  logic [W-1:0] pol_lo,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_line
        logic rise, fall, lvl;
        always_comb begin
            rise = live[g] & ~prev_q[g];
            fall = ~live[g] & prev_q[g];
            lvl  = (pol_hi[g] & live[g]) | (pol_lo[g] & ~live[g]);
            if (kind[g]) begin
                hit[g] = (pol_hi[g] & rise) | (pol_lo[g] & fall);
            end else begin
                hit[g] = lvl;
            end
        end
    end
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl #(
    parameter int LINES       = 8,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  line_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    output logic              irq_o
);
    import irq_ctrl_pkg::*;

    localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFS_LIVE);
    localparam logic [ADDR_W-1:0] A_KIND  = ADDR_W'(OFS_KIND);
    localparam logic [ADDR_W-1:0] A_POLHI = ADDR_W'(OFS_POLHI);
    localparam logic [ADDR_W-1:0] A_POLLO = ADDR_W'(OFS_POLLO);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACKCLR);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);

    typedef struct packed {
        logic [LINES-1:0] kind;
        logic [LINES-1:0] pol_hi;
        logic [LINES-1:0] pol_lo;
        logic [LINES-1:0] latched;
        logic [LINES-1:0] enable;
        logic             irq;
    } ctrl_state_t;

    ctrl_state_t      st_d, st_q;
    logic [LINES-1:0] live_w;
    logic [LINES-1:0] hit_w;
    logic [LINES-1:0] ack_w;
    logic             mapped_w;

    irq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dout  (live_w)
    );

    irq_detect #(.W(LINES)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (live_w),
        .kind   (st_q.kind),
        .pol_hi (st_q.pol_hi),
        .pol_lo (st_q.pol_lo),
        .hit    (hit_w)
    );

    always_comb begin
        st_d  = st_q;
        ack_w = '0;
        if (reg_wr) begin
            case (reg_addr)
                A_KIND:  st_d.kind   = reg_wdata;
                A_POLHI: st_d.pol_hi = reg_wdata;
                A_POLLO: st_d.pol_lo = reg_wdata;
                A_ACK:   ack_w       = reg_wdata;
                A_ENSET: st_d.enable = st_q.enable | reg_wdata;
                A_ENCLR: st_d.enable = st_q.enable & ~reg_wdata;
                default: ;
            endcase
        end
        st_d.latched = (st_q.latched | hit_w) & ~ack_w;
        st_d.irq     = |(st_q.latched & st_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        mapped_w  = 1'b1;
        case (reg_addr)
            A_LIVE:  reg_rdata = live_w;
            A_KIND:  reg_rdata = st_q.kind;
            A_POLHI: reg_rdata = st_q.pol_hi;
            A_POLLO: reg_rdata = st_q.pol_lo;
            A_ACK:   reg_rdata = '0;
            A_ENSET: reg_rdata = st_q.enable;
            A_ENCLR: reg_rdata = st_q.enable;
            A_STAT:  reg_rdata = st_q.latched;
            default: mapped_w  = 1'b0;
        endcase
    end

    assign irq_o = st_q.irq;

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.latched & st_q.enable)) |=> irq_o);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st_q.latched & st_q.enable)) |=> !irq_o);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ACK) |=> ((st_q.latched & $past(reg_wdata)) == '0));

    // R7
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENSET) |=> ((st_q.enable & $past(reg_wdata)) == $past(reg_wdata)));

    // R7
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENCLR) |=> ((st_q.enable & $past(reg_wdata)) == '0));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !mapped_w) |=> ($stable(st_q.enable) && $stable(st_q.kind)
                                   && $stable(st_q.pol_hi) && $stable(st_q.pol_lo)));

    // R5
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_ACK) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_periph_irq_ctrl.sv
module tb_periph_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_in = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'hFF;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    periph_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'hFF; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        reg_addr = 8'hFF;
    endtask

    task automatic drive_lines(input logic [7:0] v);
        @(negedge clk);
        line_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 live",  8'h10, 8'h00);
        rd_chk("R1 kind",  8'h11, 8'h00);
        rd_chk("R1 polhi", 8'h12, 8'h00);
        rd_chk("R1 pollo", 8'h13, 8'h00);
        rd_chk("R1 enable",8'h15, 8'h00);
        rd_chk("R1 stat",  8'h18, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_live();
        @(negedge clk);
        line_in = 8'hA5;
        @(negedge clk);
        rd_chk("R2 live after one edge", 8'h10, 8'h00);
        @(negedge clk);
        rd_chk("R2 live after two edges", 8'h10, 8'hA5);
        repeat (3) @(negedge clk);
        rd_chk("R3 no polarity never latches", 8'h18, 8'h00);
        drive_lines(8'h00);
    endtask

    task automatic t_cfg();
        wr(8'h11, 8'h0F);
        wr(8'h12, 8'h33);
        wr(8'h13, 8'h55);
        rd_chk("R10 kind",  8'h11, 8'h0F);
        rd_chk("R10 polhi", 8'h12, 8'h33);
        rd_chk("R10 pollo", 8'h13, 8'h55);
        wr(8'h11, 8'h00);
        wr(8'h12, 8'h00);
        wr(8'h13, 8'h00);
        wr(8'h14, 8'hFF);
    endtask

    task automatic t_level();
        wr(8'h12, 8'h01);
        wr(8'h13, 8'h02);
        repeat (2) @(negedge clk);
        rd_chk("R3 low level latches", 8'h18, 8'h02);
        drive_lines(8'h01);
        rd_chk("R3 high level latches", 8'h18, 8'h03);
        wr(8'h14, 8'h03);
        rd_chk("R5 clear wins over active level", 8'h18, 8'h00);
        @(negedge clk);
        rd_chk("R6 persistent level relatches", 8'h18, 8'h03);
        drive_lines(8'h02);
        wr(8'h14, 8'hFF);
        @(negedge clk);
        rd_chk("R3 inactive level stays clear", 8'h18, 8'h00);
        wr(8'h12, 8'h00);
        wr(8'h13, 8'h00);
        drive_lines(8'h00);
        wr(8'h14, 8'hFF);
    endtask

    task automatic t_edge();
        wr(8'h11, 8'h07);
        wr(8'h12, 8'h05);
        wr(8'h13, 8'h06);
        drive_lines(8'h07);
        rd_chk("R4 rising edges latch", 8'h18, 8'h05);
        wr(8'h14, 8'hFF);
        repeat (3) @(negedge clk);
        rd_chk("R4 steady level does not relatch", 8'h18, 8'h00);
        drive_lines(8'h00);
        rd_chk("R4 falling edges latch", 8'h18, 8'h06);
        wr(8'h14, 8'h02);
        rd_chk("R5 partial clear", 8'h18, 8'h04);
        rd_chk("R5 clear offset reads zero", 8'h14, 8'h00);
    endtask

    task automatic t_enable();
        wr(8'h15, 8'h0A);
        rd_chk("R7 set enables", 8'h15, 8'h0A);
        wr(8'h15, 8'h01);
        rd_chk("R7 zero bits keep set", 8'h15, 8'h0B);
        wr(8'h16, 8'h02);
        rd_chk("R7 clear enables", 8'h15, 8'h09);
        rd_chk("R7 enable at clear offset", 8'h16, 8'h09);
        chk("R8 masked latch no irq", {7'd0, irq_o}, 8'h00);
        wr(8'h15, 8'h04);
        chk("R8 irq one edge late", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        chk("R8 irq asserts", {7'd0, irq_o}, 8'h01);
        wr(8'h14, 8'h04);
        chk("R8 irq holds one edge", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        chk("R8 irq drops", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_unmapped();
        rd_chk("R9 read 0x17", 8'h17, 8'h00);
        rd_chk("R9 read 0x00", 8'h00, 8'h00);
        rd_chk("R9 read 0x19", 8'h19, 8'h00);
        wr(8'h17, 8'hFF);
        wr(8'h20, 8'hFF);
        rd_chk("R9 enable untouched", 8'h15, 8'h0D);
        rd_chk("R9 kind untouched", 8'h11, 8'h07);
        rd_chk("R9 stat untouched", 8'h18, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_live();
        t_cfg();
        t_level();
        t_edge();
        t_enable();
        t_unmapped();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule